// File: doc/BRIEF.md
# TDM Serial Audio Receiver

This block pulls one playback sample per frame out of a serial audio stream. The stream can be multi-slot TDM, I2S or left-justified. The stream's bit clock, frame sync and serial data arrive as plain inputs. They are synchronised into the system clock domain and acted on at the chosen bit-clock edge. Static configuration inputs set the framing:

- which edge samples the line;
- which frame-sync transition opens a frame;
- the bit delay before slot 0;
- the slot width and the audio word width;
- the justification of the word inside its slot;
- which slot or slots feed the output.

The source select picks one of four outputs: a mono slot named by an address-offset input, the left slot, the right slot, or the average of left and right. The chosen word is sign-extended to 32 bits. The number of slots in a frame is never programmed. The block measures each frame's length in bit clocks and compares it against the slot layout. A slot that does not fit inside the frame yields a zero (muted) sample. The result for a frame is issued, with a one-cycle strobe, when the next frame start is seen.

Top module: `tdm_audio_rx`

## Requirements
- R1: `cfg_start_rise_i`=1 makes a low-to-high frame-sync transition (seen at consecutive active bit-clock edges) start a frame. With 0, a high-to-low transition starts a frame. Bit position 0 of the frame is the bit sampled at that edge.
- R2: `cfg_fall_edge_i`=0 samples frame sync and data on bit-clock rising edges. With 1, they are sampled on falling edges; edges of the other direction are ignored.
- R3: slot 0 begins `cfg_offset_i` bit positions after the frame start. Slot k occupies positions offset+k*L to offset+k*L+L-1, where L is the slot length. Each slot is received MSB first.
- R4: `cfg_slot_len_i` selects L: 00 gives 16 bits, 01 gives 24 bits, 10 or 11 gives 32 bits.
- R5: `cfg_word_len_i` selects W: 00 gives 16 bits, 01 gives 20, 10 gives 24 and 11 gives 32. The effective word length is min(W, L), and the word is sign-extended from its top bit to 32 bits.
- R6: with `cfg_right_just_i`=0 the word is the first (most significant) bits of the slot. With 1 it is the last (least significant) bits of the slot.
- R7: `cfg_src_i` selects the output: 00 gives slot `addr_slot_i`, 01 gives slot `cfg_slot_l_i`, 10 gives slot `cfg_slot_r_i`, and 11 gives the downmix.
- R8: the downmix is the sum of the two sign-extended words (slots `cfg_slot_l_i` and `cfg_slot_r_i`) shifted right arithmetically by one, i.e. floor((L+R)/2).
- R9: a slot whose last position is at or beyond the measured frame length contributes a zero word. In downmix each of the two slots is muted on its own.
- R10: `sample_valid_o` pulses for exactly one clock, SYNC_STAGES+1 clocks after the bit-clock edge that starts the next frame. The frame start that follows reset yields no pulse.
- R11: after reset `sample_valid_o` is 0 and `sample_o` is 0. `sample_o` holds its value between pulses.
- R12: the frame length is the number of active edges between two frame starts. It may change from frame to frame, and muting follows each frame's own length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk_i | input | 1 | Serial bit clock |
| fsync_i | input | 1 | Frame sync |
| sdin_i | input | 1 | Serial data in |
| cfg_fall_edge_i | input | 1 | 1: sample on falling bit-clock edge |
| cfg_start_rise_i | input | 1 | 1: frame starts on low-to-high sync |
| cfg_offset_i | input | 5 | Bit delay from frame start to slot 0 |
| cfg_slot_len_i | input | 2 | Slot length code |
| cfg_word_len_i | input | 2 | Word length code |
| cfg_right_just_i | input | 1 | 1: word right-justified in slot |
| cfg_src_i | input | 2 | Output source select |
| cfg_slot_l_i | input | 4 | Left slot index |
| cfg_slot_r_i | input | 4 | Right slot index |
| addr_slot_i | input | 4 | Mono slot index from address offset |
| sample_o | output | 32 | Signed output sample |
| sample_valid_o | output | 1 | One-cycle strobe for sample_o |

## Verification
The assertions take several things for granted:

- configuration inputs are only changed while reset is asserted;
- each bit-clock level lasts at least two system clocks, so two frame starts can never be one clock apart;
- every frame is at least two bits long.

The stimulus applies each new configuration under reset, holds each bit-clock phase for two clocks, and keeps frame sync asserted for the first half of every frame. Data bits are random, so both signs of every word length are driven.

// File: rtl/tdm_rx_pkg.sv
package tdm_rx_pkg;

  typedef enum logic [1:0] {
    SRC_MONO  = 2'b00,
    SRC_LEFT  = 2'b01,
    SRC_RIGHT = 2'b10,
    SRC_MIX   = 2'b11
  } src_sel_e;

  // slot length in bits from its 2-bit code
  function automatic int unsigned slot_bits(input logic [1:0] code);
    case (code)
      2'b00:   return 16;
      2'b01:   return 24;
      default: return 32;
    endcase
  endfunction

  // audio word length in bits from its 2-bit code
  function automatic int unsigned word_bits(input logic [1:0] code);
    case (code)
      2'b00:   return 16;
      2'b01:   return 20;
      2'b10:   return 24;
      default: return 32;
    endcase
  endfunction

endpackage

// File: rtl/tdm_rx_sync.sv
module tdm_rx_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/tdm_rx_front.sv
module tdm_rx_front #(
  parameter int SYNC_STAGES = 2,
  parameter int POS_W       = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bclk_i,
  input  logic             fsync_i,
  input  logic             sdin_i,
  input  logic             cfg_fall_edge_i,
  input  logic             cfg_start_rise_i,
  output logic             bit_stb_o,
  output logic             bit_val_o,
  output logic             frame_start_o,
  output logic [POS_W-1:0] cur_pos_o,
  output logic [POS_W-1:0] frame_len_o,
  output logic             frame_seen_o
);

  logic [2:0]       lines_q;
  logic             bclk_s, fs_s, sd_s;
  logic             bclk_last;
  logic             fs_prev;
  logic             seen_q;
  logic [POS_W-1:0] pos_q;
  logic             edge_rise, edge_fall;

  tdm_rx_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({bclk_i, fsync_i, sdin_i}),
    .q   (lines_q)
  );

  assign bclk_s = lines_q[2];
  assign fs_s   = lines_q[1];
  assign sd_s   = lines_q[0];

  assign edge_rise = bclk_s & ~bclk_last;
  assign edge_fall = ~bclk_s & bclk_last;
  assign bit_stb_o = cfg_fall_edge_i ? edge_fall : edge_rise;
  assign bit_val_o = sd_s;

  assign frame_start_o = bit_stb_o && (fs_s == cfg_start_rise_i)
                         && (fs_prev != cfg_start_rise_i);

  assign cur_pos_o    = frame_start_o ? '0 : pos_q;
  assign frame_len_o  = pos_q;
  assign frame_seen_o = seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bclk_last <= 1'b0;
      fs_prev   <= ~cfg_start_rise_i;
      seen_q    <= 1'b0;
      pos_q     <= '0;
    end else begin
      bclk_last <= bclk_s;
      if (bit_stb_o) begin
        fs_prev <= fs_s;
        if (frame_start_o) begin
          pos_q  <= POS_W'(1);
          seen_q <= 1'b1;
        end else if (pos_q != '1) begin
          pos_q <= pos_q + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/tdm_rx_slot_cap.sv
module tdm_rx_slot_cap
  import tdm_rx_pkg::*;
#(
  parameter int POS_W    = 10,
  parameter int SAMPLE_W = 32,
  parameter int IDX_W    = 4,
  parameter int OFF_W    = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_stb_i,
  input  logic             bit_val_i,
  input  logic             frame_start_i,
  input  logic [POS_W-1:0] cur_pos_i,
  input  logic [POS_W-1:0] frame_len_i,
  input  logic [OFF_W-1:0] cfg_offset_i,
  input  logic [IDX_W-1:0] slot_idx_i,
  input  logic [1:0]       slot_len_i,
  output logic [SAMPLE_W-1:0] cap_o,
  output logic             muted_o
);

  localparam int W = POS_W + 2;

  logic [W-1:0] slen_w, base_w, begin_w, end_w, pos_w;
  logic         in_slot;
  logic [SAMPLE_W-1:0] cap_q;

  assign slen_w  = W'(slot_bits(slot_len_i));
  assign base_w  = W'(slot_idx_i) * slen_w;
  assign begin_w = W'(cfg_offset_i) + base_w;
  assign end_w   = begin_w + slen_w;
  assign pos_w   = W'(cur_pos_i);

  assign in_slot = (pos_w >= begin_w) && (pos_w < end_w);
  assign muted_o = end_w > W'(frame_len_i);
  assign cap_o   = cap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_q <= '0;
    end else if (bit_stb_i) begin
      if (frame_start_i) begin
        cap_q <= in_slot ? SAMPLE_W'(bit_val_i) : '0;
      end else if (in_slot) begin
        cap_q <= {cap_q[SAMPLE_W-2:0], bit_val_i};
      end
    end
  end

endmodule

// File: rtl/tdm_rx_word.sv
module tdm_rx_word
  import tdm_rx_pkg::*;
#(
  parameter int SAMPLE_W = 32
) (
  input  logic [SAMPLE_W-1:0] cap_i,
  input  logic [1:0]          slot_len_i,
  input  logic [1:0]          word_len_i,
  input  logic                right_just_i,
  input  logic                muted_i,
  output logic [SAMPLE_W-1:0] word_o
);

  int unsigned slen, wlen, ewl;
  logic [SAMPLE_W-1:0] aligned;
  logic sign;

  always_comb begin
    slen    = slot_bits(slot_len_i);
    wlen    = word_bits(word_len_i);
    ewl     = (wlen < slen) ? wlen : slen;
    aligned = right_just_i ? cap_i : (cap_i >> (slen - ewl));
    sign    = aligned[ewl-1];
    for (int i = 0; i < SAMPLE_W; i++) begin
      word_o[i] = (muted_i) ? 1'b0 : ((i < int'(ewl)) ? aligned[i] : sign);
    end
  end

endmodule

// File: rtl/tdm_audio_rx.sv
module tdm_audio_rx
  import tdm_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int POS_W       = 10,
  parameter int SAMPLE_W    = 32,
  parameter int IDX_W       = 4,
  parameter int OFF_W       = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bclk_i,
  input  logic                fsync_i,
  input  logic                sdin_i,
  input  logic                cfg_fall_edge_i,
  input  logic                cfg_start_rise_i,
  input  logic [OFF_W-1:0]    cfg_offset_i,
  input  logic [1:0]          cfg_slot_len_i,
  input  logic [1:0]          cfg_word_len_i,
  input  logic                cfg_right_just_i,
  input  logic [1:0]          cfg_src_i,
  input  logic [IDX_W-1:0]    cfg_slot_l_i,
  input  logic [IDX_W-1:0]    cfg_slot_r_i,
  input  logic [IDX_W-1:0]    addr_slot_i,
  output logic [SAMPLE_W-1:0] sample_o,
  output logic                sample_valid_o
);

  localparam int NCH = 2;

  logic             bit_stb, bit_val, frame_start, frame_seen;
  logic [POS_W-1:0] cur_pos, frame_len;

  logic [IDX_W-1:0]    ch_slot [NCH];
  logic [SAMPLE_W-1:0] ch_cap  [NCH];
  logic [SAMPLE_W-1:0] ch_word [NCH];
  logic [NCH-1:0]      ch_mute;

  logic [SAMPLE_W:0]   mix_sum;
  logic [SAMPLE_W-1:0] mix_val;
  logic [SAMPLE_W-1:0] pick;
  logic                mix_unused_lsb;
  src_sel_e            src;

  assign src = src_sel_e'(cfg_src_i);

  tdm_rx_front #(.SYNC_STAGES(SYNC_STAGES), .POS_W(POS_W)) u_front (
    .clk              (clk),
    .rst              (rst),
    .bclk_i           (bclk_i),
    .fsync_i          (fsync_i),
    .sdin_i           (sdin_i),
    .cfg_fall_edge_i  (cfg_fall_edge_i),
    .cfg_start_rise_i (cfg_start_rise_i),
    .bit_stb_o        (bit_stb),
    .bit_val_o        (bit_val),
    .frame_start_o    (frame_start),
    .cur_pos_o        (cur_pos),
    .frame_len_o      (frame_len),
    .frame_seen_o     (frame_seen)
  );

  // channel 0: mono/left/right choice; channel 1: right slot for downmix
  always_comb begin
    case (src)
      SRC_MONO:  ch_slot[0] = addr_slot_i;
      SRC_RIGHT: ch_slot[0] = cfg_slot_r_i;
      default:   ch_slot[0] = cfg_slot_l_i;
    endcase
    ch_slot[1] = cfg_slot_r_i;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    tdm_rx_slot_cap #(
      .POS_W(POS_W), .SAMPLE_W(SAMPLE_W), .IDX_W(IDX_W), .OFF_W(OFF_W)
    ) u_cap (
      .clk           (clk),
      .rst           (rst),
      .bit_stb_i     (bit_stb),
      .bit_val_i     (bit_val),
      .frame_start_i (frame_start),
      .cur_pos_i     (cur_pos),
      .frame_len_i   (frame_len),
      .cfg_offset_i  (cfg_offset_i),
      .slot_idx_i    (ch_slot[c]),
      .slot_len_i    (cfg_slot_len_i),
      .cap_o         (ch_cap[c]),
      .muted_o       (ch_mute[c])
    );

    tdm_rx_word #(.SAMPLE_W(SAMPLE_W)) u_word (
      .cap_i        (ch_cap[c]),
      .slot_len_i   (cfg_slot_len_i),
      .word_len_i   (cfg_word_len_i),
      .right_just_i (cfg_right_just_i),
      .muted_i      (ch_mute[c]),
      .word_o       (ch_word[c])
    );
  end

  assign mix_sum        = {ch_word[0][SAMPLE_W-1], ch_word[0]}
                        + {ch_word[1][SAMPLE_W-1], ch_word[1]};
  assign mix_val        = mix_sum[SAMPLE_W:1];
  assign mix_unused_lsb = mix_sum[0];
  assign pick           = (src == SRC_MIX) ? mix_val : ch_word[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      sample_o       <= '0;
      sample_valid_o <= 1'b0;
    end else begin
      sample_valid_o <= 1'b0;
      if (frame_start && frame_seen) begin
        sample_o       <= pick;
        sample_valid_o <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/tdm_audio_rx_chk.sv
module tdm_audio_rx_chk #(
  parameter int SAMPLE_W = 32
) (
  input logic                clk,
  input logic                rst,
  input logic                frame_start,
  input logic                mute0,
  input logic                mute1,
  input logic [1:0]          cfg_src_i,
  input logic [1:0]          cfg_slot_len_i,
  input logic [1:0]          cfg_word_len_i,
  input logic [SAMPLE_W-1:0] sample_o,
  input logic                sample_valid_o
);

  logic rst_q = 1'b0;
  logic ewl16;

  assign ewl16 = (cfg_word_len_i == 2'b00) || (cfg_slot_len_i == 2'b00);

  always @(posedge clk) begin
    if (rst_q) begin
      assert_reset_clear_R11: assert (!sample_valid_o && sample_o == '0);
    end
    rst_q <= rst;
  end

  assert_valid_single_R10: assert property (@(posedge clk) disable iff (rst)
    sample_valid_o |=> !sample_valid_o);

  assert_valid_after_start_R10: assert property (@(posedge clk) disable iff (rst)
    sample_valid_o |-> $past(frame_start));

  assert_mute_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (sample_valid_o && cfg_src_i != 2'b11 && $past(mute0)) |-> (sample_o == '0));

  assert_mix_mute_R8: assert property (@(posedge clk) disable iff (rst)
    (sample_valid_o && cfg_src_i == 2'b11 && $past(mute0) && $past(mute1))
      |-> (sample_o == '0));

  assert_sign_ext_R5: assert property (@(posedge clk) disable iff (rst)
    (sample_valid_o && cfg_src_i != 2'b11 && ewl16)
      |-> ($countones(sample_o[SAMPLE_W-1:15]) == 0
           || $countones(sample_o[SAMPLE_W-1:15]) == SAMPLE_W - 15));

endmodule

bind tdm_audio_rx tdm_audio_rx_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .frame_start    (frame_start),
  .mute0          (ch_mute[0]),
  .mute1          (ch_mute[1]),
  .cfg_src_i      (cfg_src_i),
  .cfg_slot_len_i (cfg_slot_len_i),
  .cfg_word_len_i (cfg_word_len_i),
  .sample_o       (sample_o),
  .sample_valid_o (sample_valid_o)
);

// File: tb/tb_tdm_audio_rx.sv
module tb_tdm_audio_rx;

  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bclk = 1'b0, fsync = 1'b0, sdin = 1'b0;
  logic cfg_fall = 1'b0, cfg_rise = 1'b0;
  logic [4:0] cfg_off = '0;
  logic [1:0] cfg_sl = 2'b10, cfg_wl = 2'b11, cfg_src = 2'b01;
  logic cfg_rj = 1'b0;
  logic [3:0] cfg_l = '0, cfg_r = 4'd1, cfg_addr = '0;
  logic [31:0] sample;
  logic valid;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  string cur_req = "R1";

  logic fb [0:1023];
  int  q_t[$];
  logic [31:0] q_v[$];
  logic pending = 1'b0;
  logic [31:0] pending_val = '0;

  tdm_audio_rx dut (
    .clk (clk), .rst (rst), .bclk_i (bclk), .fsync_i (fsync), .sdin_i (sdin),
    .cfg_fall_edge_i (cfg_fall), .cfg_start_rise_i (cfg_rise),
    .cfg_offset_i (cfg_off), .cfg_slot_len_i (cfg_sl), .cfg_word_len_i (cfg_wl),
    .cfg_right_just_i (cfg_rj), .cfg_src_i (cfg_src), .cfg_slot_l_i (cfg_l),
    .cfg_slot_r_i (cfg_r), .addr_slot_i (cfg_addr),
    .sample_o (sample), .sample_valid_o (valid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc++;

  function automatic int sl_of();
    return (cfg_sl == 2'b00) ? 16 : (cfg_sl == 2'b01) ? 24 : 32;
  endfunction

  function automatic int wl_of();
    case (cfg_wl)
      2'b00: return 16;
      2'b01: return 20;
      2'b10: return 24;
      default: return 32;
    endcase
  endfunction

  // expected word of one slot for a frame of n bits (R3-R6, R9)
  function automatic logic [31:0] chan(int slot, int n);
    int sl, first, ewl;
    logic [31:0] v, r;
    sl = sl_of();
    first = cfg_off + slot * sl;
    if (first + sl > n) return 32'd0;
    v = 0;
    for (int i = 0; i < sl; i++) v = {v[30:0], fb[first + i]};
    ewl = (wl_of() < sl) ? wl_of() : sl;
    if (!cfg_rj) v = v >> (sl - ewl);
    for (int i = 0; i < 32; i++) r[i] = (i < ewl) ? v[i] : v[ewl-1];
    return r;
  endfunction

  function automatic logic [31:0] model(int n);
    longint a, b, s;
    case (cfg_src)
      2'b00: return chan(cfg_addr, n);
      2'b01: return chan(cfg_l, n);
      2'b10: return chan(cfg_r, n);
      default: begin
        a = longint'($signed(chan(cfg_l, n)));
        b = longint'($signed(chan(cfg_r, n)));
        s = a + b;
        if (s < 0) s = -((-s + 1) / 2); else s = s / 2;
        return s[31:0];
      end
    endcase
  endfunction

  // per-clock comparison against the expected pulse schedule (R10)
  always @(negedge clk) begin
    if (!rst) begin
      tests++;
      if (q_t.size() > 0 && q_t[0] == cyc) begin
        if (!valid || sample !== q_v[0]) begin
          fails++;
          $display("FAIL %s R10 sample: actual valid=%b %h expected valid=1 %h",
                   cur_req, valid, sample, q_v[0]);
        end
        void'(q_t.pop_front());
        void'(q_v.pop_front());
      end else if (valid !== 1'b0) begin
        fails++;
        $display("FAIL %s R10 stray strobe: actual %b expected 0", cur_req, valid);
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    pending = 1'b0;
    q_t.delete();
    q_v.delete();
    bclk = cfg_fall;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    tests++;
    if (valid !== 1'b0 || sample !== 32'd0) begin
      fails++;
      $display("FAIL R11 reset state: actual %b %h expected 0 00000000", valid, sample);
    end
  endtask

  task automatic send_frame(int n);
    for (int i = 0; i < n; i++) fb[i] = 1'($urandom);
    for (int i = 0; i < n; i++) begin
      bclk  = cfg_fall;
      fsync = (i < n / 2) ? cfg_rise : ~cfg_rise;
      sdin  = fb[i];
      repeat (2) @(negedge clk);
      bclk = ~cfg_fall;
      if (i == 0 && pending) begin
        q_t.push_back(cyc + LAT);
        q_v.push_back(pending_val);
      end
      repeat (2) @(negedge clk);
    end
    pending_val = model(n);
    pending = 1'b1;
  endtask

  task automatic run_cfg(string tag, logic fall, logic rise, int off, logic [1:0] sl,
                         logic [1:0] wl, logic rj, logic [1:0] src, int l, int r,
                         int addr, int frames, int n);
    cur_req = tag;
    cfg_fall = fall; cfg_rise = rise; cfg_off = 5'(off); cfg_sl = sl; cfg_wl = wl;
    cfg_rj = rj; cfg_src = src; cfg_l = 4'(l); cfg_r = 4'(r); cfg_addr = 4'(addr);
    do_reset();
    for (int f = 0; f < frames + 1; f++) send_frame(n);
    repeat (8) @(negedge clk);
    tests++;
    if (q_t.size() != 0) begin
      fails++;
      $display("FAIL %s R10 missing strobes: actual %0d pending expected 0", tag, q_t.size());
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    // R3 R6 R7: I2S-style, one bit delay, 24-bit word left-justified, left slot
    run_cfg("R3_R6_R7", 1'b0, 1'b0, 1, 2'b10, 2'b10, 1'b0, 2'b01, 0, 1, 0, 5, 64);
    // R1 R2: low-to-high start, falling-edge sampling, 16-bit slots, right slot
    run_cfg("R1_R2_R4", 1'b1, 1'b1, 0, 2'b00, 2'b00, 1'b0, 2'b10, 0, 1, 0, 5, 32);
    // R8: downmix of slots 3 and 6 in an eight-slot frame
    run_cfg("R8", 1'b0, 1'b1, 0, 2'b00, 2'b00, 1'b0, 2'b11, 3, 6, 0, 8, 128);
    // R6: 20-bit word right-justified in a 32-bit slot
    run_cfg("R6", 1'b1, 1'b0, 1, 2'b10, 2'b01, 1'b1, 2'b01, 1, 0, 0, 5, 64);
    // R4 R5 R7: mono slot from address offset, 24-bit slot caps a 32-bit word
    run_cfg("R4_R5_R7", 1'b0, 1'b1, 2, 2'b01, 2'b11, 1'b0, 2'b00, 0, 0, 5, 5, 192);
    // R5: 16-bit word in 32-bit slot, sign extension
    run_cfg("R5", 1'b0, 1'b0, 0, 2'b11, 2'b00, 1'b0, 2'b01, 1, 0, 0, 6, 64);
    // R9: slot wholly beyond the frame end
    run_cfg("R9", 1'b0, 1'b0, 0, 2'b10, 2'b11, 1'b0, 2'b01, 2, 0, 0, 3, 64);
    // R9: slot one bit past the frame end
    run_cfg("R9_partial", 1'b0, 1'b0, 1, 2'b10, 2'b11, 1'b0, 2'b01, 1, 0, 0, 3, 64);
    // R8 R9: downmix with right slot muted
    run_cfg("R8_R9", 1'b0, 1'b1, 0, 2'b10, 2'b11, 1'b0, 2'b11, 0, 3, 0, 4, 96);

    // R12: frame length changes frame by frame; slot 3 fits only the long frames
    cur_req = "R12";
    cfg_fall = 1'b0; cfg_rise = 1'b0; cfg_off = 0; cfg_sl = 2'b10; cfg_wl = 2'b11;
    cfg_rj = 1'b0; cfg_src = 2'b01; cfg_l = 4'd3; cfg_r = 4'd0;
    do_reset();
    send_frame(64);
    send_frame(160);
    send_frame(64);
    send_frame(128);
    send_frame(160);
    send_frame(64);
    repeat (8) @(negedge clk);
    tests++;
    if (q_t.size() != 0) begin
      fails++;
      $display("FAIL R12 missing strobes: actual %0d pending expected 0", q_t.size());
    end

    // R11: reset clears a held nonzero sample
    do_reset();

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule